// File: doc/BRIEF.md
# Read-Modify-Write Bus Cycle Sequencer

This block runs the memory side of a read-modify-write instruction for a small processor core whose data width can be 8 or 16 bits. A one-cycle `start` pulse hands it an effective data address, a width flag, an operation code, the accumulator and the incoming carry. It then issues the bus cycles in a fixed order: an optional dummy read for indexed addressing, one or two data reads, a width-dependent filler cycle, one internal modify cycle, and one or two writes. Every bus cycle uses a request/acknowledge handshake and waits as long as the memory needs.

A 16-bit operand is fetched low byte first at rising addresses and stored back high byte first at falling addresses. In 8-bit mode the filler cycle writes the unmodified byte back to its own address. In 16-bit mode that cycle reads the high byte a second time and discards the value. The modified value, the new carry and the zero flag stay on the outputs after `done` pulses.

Top module: `rmw_sequencer`

## Requirements
- R1: After reset the block is idle: `bus_req`, `busy` and `done` are low and `result` is zero.
- R2: In 16-bit mode the first two data reads address A and then A+1 (24-bit wrap), filling the low and then the high byte of the buffer.
- R3: In 16-bit mode the cycle after the high-byte read is a second read of A+1, and its data does not change the result.
- R4: In 8-bit mode there is one data read at A, followed by a write of that same unmodified byte to A.
- R5: Between the last read or filler cycle and the first write there is exactly one busy cycle with `bus_req` low (the modify cycle).
- R6: In 16-bit mode the writes go to A+1 with the result's high byte, then to A with its low byte. In 8-bit mode the only modified write goes to A.
- R7: `op_sel` encoding: 0 shift left, 1 decrement, 2 increment, 3 logical shift right, 4 rotate left, 5 rotate right, 6 test-and-reset (value AND NOT accumulator), 7 test-and-set (value OR accumulator). All act on 8 or 16 bits, and in 8-bit mode `result[15:8]` reads zero.
- R8: For ops 6 and 7, `zero_out` is set when value AND accumulator (at the active width) is zero. For ops 0 to 5 it is set when the result is zero.
- R9: Shifts and rotates place the bit shifted out in `carry_out`, and rotates shift `carry_in` in. Ops 1, 2, 6 and 7 leave `carry_out` equal to `carry_in`.
- R10: With `indexed` high, one extra read at A comes before the data reads, and its data is discarded.
- R11: While `bus_req` is high and `bus_ack` is low, `bus_req`, `bus_we`, `bus_addr` and `bus_wdata` hold steady, and the sequence advances only on acknowledge.
- R12: `done` is a one-cycle pulse in the cycle after the last write is acknowledged, with `busy` low. A `start` pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a sequence (taken only when idle) |
| wide | input | 1 | 1 = 16-bit data, 0 = 8-bit |
| indexed | input | 1 | Insert the leading dummy read |
| op_sel | input | 3 | Modify operation, encoding in R7 |
| addr_in | input | 24 | Effective data address A |
| acc_in | input | 16 | Accumulator operand for test-and-set/reset |
| carry_in | input | 1 | Carry flag before the instruction |
| bus_req | output | 1 | Bus cycle request |
| bus_we | output | 1 | 1 = write cycle |
| bus_addr | output | 24 | Bus address |
| bus_wdata | output | 8 | Write data byte |
| bus_ack | input | 1 | Memory acknowledges the current cycle |
| bus_rdata | input | 8 | Read data, valid with acknowledge |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence complete pulse |
| result | output | 16 | Modified value |
| carry_out | output | 1 | Carry after the operation |
| zero_out | output | 1 | Zero flag after the operation |

## Verification
The memory model returns junk bytes for the dummy read and for the 16-bit re-read. A sequencer that latched either of them would change the result or the written bytes. The bench also runs a 16-bit access at address 0xFFFFFF, which catches a counter that does not wrap or that writes the bytes in the wrong order. Acknowledge delays are random, and a second `start` is pulsed mid-sequence, so a design that advanced without acknowledge or restarted while busy would break the recorded bus trace. Directed cases cover increment of 0xFF to zero, decrement of zero, rotates with carry in, and test-and-reset with disjoint bits, to expose flag errors.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

    typedef enum logic [2:0] {
        OP_ASL = 3'd0,
        OP_DEC = 3'd1,
        OP_INC = 3'd2,
        OP_LSR = 3'd3,
        OP_ROL = 3'd4,
        OP_ROR = 3'd5,
        OP_TRB = 3'd6,
        OP_TSB = 3'd7
    } rmw_op_e;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_DUMMY  = 3'd1,
        ST_RD_LO  = 3'd2,
        ST_RD_FIN = 3'd3,
        ST_FILLER = 3'd4,
        ST_MODIFY = 3'd5,
        ST_WR_HI  = 3'd6,
        ST_WR_LO  = 3'd7
    } rmw_state_e;

endpackage

// File: rtl/rmw_alu.sv
module rmw_alu
    import rmw_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  rmw_op_e           op_i,
    input  logic              wide_i,
    input  logic [DATA_W-1:0] val_i,
    input  logic [DATA_W-1:0] acc_i,
    input  logic              carry_i,
    output logic [DATA_W-1:0] res_o,
    output logic              carry_o,
    output logic              zero_o
);
    localparam int BYTE_W = DATA_W / 2;
    localparam logic [DATA_W-1:0] LO_MASK = {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}};
    localparam logic [DATA_W-1:0] TOP_W   = {1'b1, {(DATA_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] TOP_N   = {{BYTE_W{1'b0}}, 1'b1, {(BYTE_W-1){1'b0}}};
    localparam logic [DATA_W-1:0] ONE     = {{(DATA_W-1){1'b0}}, 1'b1};

    logic [DATA_W-1:0] mask, v, a, top, cin_vec;
    logic              msb;

    always_comb begin
        mask    = wide_i ? '1 : LO_MASK;
        top     = wide_i ? TOP_W : TOP_N;
        v       = val_i & mask;
        a       = acc_i & mask;
        msb     = wide_i ? val_i[DATA_W-1] : val_i[BYTE_W-1];
        cin_vec = carry_i ? ONE : '0;
        res_o   = v;
        carry_o = carry_i;
        unique case (op_i)
            OP_ASL: begin res_o = (v << 1) & mask;           carry_o = msb;      end
            OP_DEC: begin res_o = (v - ONE) & mask;                              end
            OP_INC: begin res_o = (v + ONE) & mask;                              end
            OP_LSR: begin res_o = v >> 1;                    carry_o = v[0];     end
            OP_ROL: begin res_o = ((v << 1) | cin_vec) & mask; carry_o = msb;    end
            OP_ROR: begin res_o = (v >> 1) | (carry_i ? top : '0); carry_o = v[0]; end
            OP_TRB: begin res_o = v & ~a;                                        end
            OP_TSB: begin res_o = v | a;                                         end
            default: res_o = v;
        endcase
        if (op_i == OP_TRB || op_i == OP_TSB) zero_o = ((v & a) == '0);
        else                                  zero_o = (res_o == '0);
    end
endmodule

// File: rtl/rmw_bus_drive.sv
module rmw_bus_drive
    import rmw_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  rmw_state_e          state_i,
    input  logic                wide_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W-1:0]   dbuf_i,
    output logic                req_o,
    output logic                we_o,
    output logic [ADDR_W-1:0]   addr_o,
    output logic [DATA_W/2-1:0] wdata_o
);
    localparam int BYTE_W = DATA_W / 2;

    always_comb begin
        req_o   = (state_i != ST_IDLE) && (state_i != ST_MODIFY);
        we_o    = (state_i == ST_WR_HI) || (state_i == ST_WR_LO) ||
                  ((state_i == ST_FILLER) && !wide_i);
        addr_o  = addr_i;
        wdata_o = (state_i == ST_WR_HI) ? dbuf_i[DATA_W-1:BYTE_W] : dbuf_i[BYTE_W-1:0];
    end
endmodule

// File: rtl/rmw_sequencer.sv
module rmw_sequencer
    import rmw_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                wide,
    input  logic                indexed,
    input  logic [2:0]          op_sel,
    input  logic [ADDR_W-1:0]   addr_in,
    input  logic [DATA_W-1:0]   acc_in,
    input  logic                carry_in,
    output logic                bus_req,
    output logic                bus_we,
    output logic [ADDR_W-1:0]   bus_addr,
    output logic [DATA_W/2-1:0] bus_wdata,
    input  logic                bus_ack,
    input  logic [DATA_W/2-1:0] bus_rdata,
    output logic                busy,
    output logic                done,
    output logic [DATA_W-1:0]   result,
    output logic                carry_out,
    output logic                zero_out
);
    localparam int BYTE_W = DATA_W / 2;
    localparam logic [ADDR_W-1:0] ADDR_ONE = {{(ADDR_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        rmw_state_e        state;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] dbuf;
        logic [DATA_W-1:0] acc;
        rmw_op_e           op;
        logic              wide;
        logic              carry;
        logic              zero;
        logic              done;
    } regs_t;

    regs_t r_d, r_q;

    logic [DATA_W-1:0] alu_res;
    logic              alu_carry, alu_zero;
    logic              step;

    rmw_alu #(.DATA_W(DATA_W)) alu_i (
        .op_i    (r_q.op),
        .wide_i  (r_q.wide),
        .val_i   (r_q.dbuf),
        .acc_i   (r_q.acc),
        .carry_i (r_q.carry),
        .res_o   (alu_res),
        .carry_o (alu_carry),
        .zero_o  (alu_zero)
    );

    rmw_bus_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) drive_i (
        .state_i (r_q.state),
        .wide_i  (r_q.wide),
        .addr_i  (r_q.addr),
        .dbuf_i  (r_q.dbuf),
        .req_o   (bus_req),
        .we_o    (bus_we),
        .addr_o  (bus_addr),
        .wdata_o (bus_wdata)
    );

    assign step = bus_req && bus_ack;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    r_d.addr  = addr_in;
                    r_d.op    = rmw_op_e'(op_sel);
                    r_d.wide  = wide;
                    r_d.acc   = acc_in;
                    r_d.carry = carry_in;
                    r_d.dbuf  = '0;
                    if (indexed)   r_d.state = ST_DUMMY;
                    else if (wide) r_d.state = ST_RD_LO;
                    else           r_d.state = ST_RD_FIN;
                end
            end
            ST_DUMMY: if (step) r_d.state = r_q.wide ? ST_RD_LO : ST_RD_FIN;
            ST_RD_LO: if (step) begin
                r_d.dbuf[BYTE_W-1:0] = bus_rdata;
                r_d.addr             = r_q.addr + ADDR_ONE;
                r_d.state            = ST_RD_FIN;
            end
            ST_RD_FIN: if (step) begin
                if (r_q.wide) r_d.dbuf[DATA_W-1:BYTE_W] = bus_rdata;
                else          r_d.dbuf[BYTE_W-1:0]      = bus_rdata;
                r_d.state = ST_FILLER;
            end
            ST_FILLER: if (step) r_d.state = ST_MODIFY;
            ST_MODIFY: begin
                r_d.dbuf  = alu_res;
                r_d.carry = alu_carry;
                r_d.zero  = alu_zero;
                r_d.state = r_q.wide ? ST_WR_HI : ST_WR_LO;
            end
            ST_WR_HI: if (step) begin
                r_d.addr  = r_q.addr - ADDR_ONE;
                r_d.state = ST_WR_LO;
            end
            ST_WR_LO: if (step) begin
                r_d.state = ST_IDLE;
                r_d.done  = 1'b1;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy      = (r_q.state != ST_IDLE);
    assign done      = r_q.done;
    assign result    = r_q.dbuf;
    assign carry_out = r_q.carry;
    assign zero_out  = r_q.zero;
endmodule

// File: rtl/rmw_sequencer_chk.sv
module rmw_sequencer_chk #(
    parameter int ADDR_W = 24,
    parameter int BYTE_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic              bus_req,
    input logic              bus_ack,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [BYTE_W-1:0] bus_wdata
);
    // R1
    reset_idle_chk: assert property (@(posedge clk)
        !rst_n |=> (!bus_req && !busy && !done));

    // R11
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_we) &&
                                   $stable(bus_addr) && $stable(bus_wdata)));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R5
    single_modify_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !bus_req) |=> (bus_req && bus_we));

    // R12
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !(bus_req && bus_ack)) |=> busy);
endmodule

bind rmw_sequencer rmw_sequencer_chk #(.ADDR_W(ADDR_W), .BYTE_W(DATA_W/2)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .bus_req   (bus_req),
    .bus_ack   (bus_ack),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
);

// File: tb/rmw_sequencer_tb_top.sv
`timescale 1ns/1ps
module rmw_sequencer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, wide = 1'b0, indexed = 1'b0;
    logic [2:0]  op_sel = '0;
    logic [23:0] addr_in = '0;
    logic [15:0] acc_in = '0;
    logic        carry_in = 1'b0;
    logic        bus_req, bus_we, bus_ack = 1'b0;
    logic [23:0] bus_addr;
    logic [7:0]  bus_wdata, bus_rdata = '0;
    logic        busy, done, carry_out, zero_out;
    logic [15:0] result;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    rmw_sequencer dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .wide(wide), .indexed(indexed),
        .op_sel(op_sel), .addr_in(addr_in), .acc_in(acc_in), .carry_in(carry_in),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_rdata(bus_rdata), .busy(busy), .done(done),
        .result(result), .carry_out(carry_out), .zero_out(zero_out)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // returns {result[15:0], carry, zero}
    function automatic logic [17:0] model(input int op, input bit w, input logic [15:0] v,
                                          input logic [15:0] a, input bit cin);
        logic [15:0] r;
        logic [7:0]  r8;
        logic        c, z;
        c = cin;
        r = '0;
        r8 = '0;
        if (w) begin
            case (op)
                0: {c, r} = {v, 1'b0};
                1: r = v - 16'd1;
                2: r = v + 16'd1;
                3: {r, c} = {1'b0, v};
                4: {c, r} = {v, cin};
                5: {r, c} = {cin, v};
                6: r = v & ~a;
                default: r = v | a;
            endcase
            z = (op >= 6) ? ((v & a) == 16'h0) : (r == 16'h0);
        end else begin
            case (op)
                0: {c, r8} = {v[7:0], 1'b0};
                1: r8 = v[7:0] - 8'd1;
                2: r8 = v[7:0] + 8'd1;
                3: {r8, c} = {1'b0, v[7:0]};
                4: {c, r8} = {v[7:0], cin};
                5: {r8, c} = {cin, v[7:0]};
                6: r8 = v[7:0] & ~a[7:0];
                default: r8 = v[7:0] | a[7:0];
            endcase
            r = {8'h00, r8};
            z = (op >= 6) ? ((v[7:0] & a[7:0]) == 8'h0) : (r8 == 8'h0);
        end
        return {r, c, z};
    endfunction

    task automatic run(input int op, input bit w, input bit idx, input logic [23:0] a,
                       input logic [15:0] v, input logic [15:0] acc, input bit cin,
                       input int maxd, input bit poke);
        logic        ewe [8];
        logic [23:0] eaddr [8];
        logic [7:0]  edat [8];
        string       etag [8];
        logic        awe [16];
        logic [23:0] aaddr [16];
        logic [7:0]  adat [16];
        logic [7:0]  rdv [4];
        logic [17:0] m;
        int ne = 0, na = 0, nrd = 0, idle_n = 0, wait_n = 0;
        bit fin = 0;
        m = model(op, w, v, acc, cin);
        if (idx) begin
            ewe[ne] = 0; eaddr[ne] = a; edat[ne] = 0; etag[ne] = "R10 dummy read"; ne++;
            rdv[nrd] = 8'hC3; nrd++;
        end
        if (w) begin
            ewe[ne] = 0; eaddr[ne] = a;         edat[ne] = 0; etag[ne] = "R2 low read";  ne++;
            ewe[ne] = 0; eaddr[ne] = a + 24'd1; edat[ne] = 0; etag[ne] = "R2 high read"; ne++;
            ewe[ne] = 0; eaddr[ne] = a + 24'd1; edat[ne] = 0; etag[ne] = "R3 re-read";   ne++;
            ewe[ne] = 1; eaddr[ne] = a + 24'd1; edat[ne] = m[17:10]; etag[ne] = "R6 high write"; ne++;
            ewe[ne] = 1; eaddr[ne] = a;         edat[ne] = m[9:2];   etag[ne] = "R6 low write";  ne++;
            rdv[nrd] = v[7:0]; rdv[nrd+1] = v[15:8]; rdv[nrd+2] = 8'h3C; nrd += 3;
        end else begin
            ewe[ne] = 0; eaddr[ne] = a; edat[ne] = 0;      etag[ne] = "R4 byte read";   ne++;
            ewe[ne] = 1; eaddr[ne] = a; edat[ne] = v[7:0]; etag[ne] = "R4 write-back";  ne++;
            ewe[ne] = 1; eaddr[ne] = a; edat[ne] = m[9:2]; etag[ne] = "R6 byte write";  ne++;
            rdv[nrd] = v[7:0]; nrd++;
        end
        nrd = 0;
        @(negedge clk);
        start = 1; wide = w; indexed = idx; op_sel = op[2:0]; addr_in = a;
        acc_in = acc; carry_in = cin;
        for (int it = 0; it < 300; it++) begin
            @(negedge clk);
            bus_ack = 0;
            start = (it == 2) && poke;
            if (start) begin
                wide = ~w; op_sel = ~op[2:0]; addr_in = ~a; indexed = ~idx;
            end
            if (done) begin fin = 1; break; end
            if (busy && !bus_req) idle_n++;
            if (bus_req) begin
                if (wait_n == 0) begin
                    bus_ack = 1;
                    if (na < 16) begin
                        awe[na] = bus_we; aaddr[na] = bus_addr; adat[na] = bus_wdata;
                    end
                    na++;
                    if (!bus_we) begin
                        bus_rdata = (nrd < 4) ? rdv[nrd] : 8'h00;
                        nrd++;
                    end
                    wait_n = $urandom_range(maxd, 0);
                end else begin
                    wait_n--;
                end
            end
        end
        start = 0;
        chk(fin, "R12 done reached", {31'd0, fin}, 32'd1);
        chk(na == ne, "R11 bus cycle count", na, ne);
        for (int i = 0; i < ne && i < na; i++) begin
            chk(awe[i] == ewe[i] && aaddr[i] == eaddr[i] && (!ewe[i] || adat[i] == edat[i]),
                etag[i], {awe[i], aaddr[i], adat[i] & {8{ewe[i]}}},
                {ewe[i], eaddr[i], edat[i] & {8{ewe[i]}}});
        end
        chk(idle_n == 1, "R5 modify cycle count", idle_n, 1);
        chk(result == m[17:2], "R7 result", result, m[17:2]);
        chk(zero_out == m[0], "R8 zero flag", zero_out, m[0]);
        chk(carry_out == m[1], "R9 carry flag", carry_out, m[1]);
        @(negedge clk);
        chk(!done && !busy && !bus_req, "R12 done pulse and idle",
            {done, busy, bus_req}, 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk(!bus_req && !busy && !done && result == 16'h0, "R1 reset state",
            {bus_req, busy, done, result}, 0);
        rst_n = 1;
        @(negedge clk);
        chk(!bus_req && !busy, "R1 idle after reset", {bus_req, busy}, 0);
        // directed corners
        run(2, 0, 0, 24'h001234, 16'h00FF, 16'h0, 0, 0, 0);  // R7 INC 8-bit to zero
        run(1, 1, 0, 24'h00FFFE, 16'h0000, 16'h0, 1, 1, 0);  // R7 DEC 16-bit underflow
        run(4, 1, 1, 24'hFFFFFF, 16'h8001, 16'h0, 1, 2, 0);  // R2 wrap, R9 ROL carry
        run(5, 0, 1, 24'h7F0000, 16'h0001, 16'h0, 1, 3, 1);  // R9 ROR, R12 poke
        run(6, 1, 0, 24'h123456, 16'hF0F0, 16'h0F0F, 0, 0, 0); // R8 TRB disjoint
        run(7, 0, 1, 24'h000010, 16'h0011, 16'h0001, 1, 1, 0); // R8 TSB overlap
        run(0, 1, 1, 24'h400000, 16'h8000, 16'h0, 0, 0, 1);  // R9 ASL carry out
        run(3, 0, 0, 24'h00ABCD, 16'h0001, 16'h0, 0, 2, 0);  // R9 LSR to zero
        for (int n = 0; n < 80; n++) begin
            run($urandom_range(7, 0), $urandom_range(1, 0), $urandom_range(1, 0),
                24'($urandom), 16'($urandom), 16'($urandom), $urandom_range(1, 0),
                $urandom_range(3, 0), ($urandom_range(3, 0) == 0));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R12 watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule